// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block is a purely combinational word shifter. It moves a data word left, right (logically or arithmetically) or around in a rotation, and it produces a shifter carry-out bit next to the result. It is meant to sit in front of an integer datapath, where the carry-out feeds the flag logic when a shifted operand is used.

The shift amount comes from one of two sources, chosen by a mode input. In immediate mode it is a small encoded field, and the block decodes that field's special values itself. In register mode it is a full data word, of which only the low byte counts. A two-bit kind field picks the operation. A carry-in is used in two cases: it is passed through when the effective amount is zero, and it is shifted into the top bit by the one-place extended rotate.

Top module: `barrel_shift_carry`

## Requirements
- R1: In immediate mode (`amt_from_reg`=0), kind 0 shifts left by `imm_amt`. An `imm_amt` of 0 returns `src_val` unchanged, and `carry_out` then equals `carry_in`.
- R2: In immediate mode, kind 1 (logical right) and kind 2 (arithmetic right) shift by `imm_amt`, and an `imm_amt` of 0 stands for a shift of WIDTH positions.
- R3: In immediate mode, kind 3 with a nonzero `imm_amt` rotates right by `imm_amt`. With `imm_amt` of 0 the result is `{carry_in, src_val[WIDTH-1:1]}` and `carry_out` is `src_val[0]`.
- R4: In register mode (`amt_from_reg`=1), kinds 0, 1, 2 and 3 select left shift, logical right, arithmetic right and rotate right. The amount is `reg_amt[7:0]` and every higher bit of `reg_amt` is ignored. The extended rotate is never chosen in this mode.
- R5: When the effective amount is zero in register mode, `result` equals `src_val` and `carry_out` equals `carry_in` for every kind.
- R6: For a left shift by n, where 1 ≤ n < WIDTH, `carry_out` is `src_val[WIDTH-n]`. At n = WIDTH the result is 0 and the carry is `src_val[0]`. Above WIDTH both are 0.
- R7: For a logical right shift by n, where 1 ≤ n ≤ WIDTH, `carry_out` is `src_val[n-1]`, and the result is 0 at n = WIDTH. Above WIDTH both are 0.
- R8: For an arithmetic right shift by n, where 1 ≤ n < WIDTH, `carry_out` is `src_val[n-1]` and the vacated bits copy the sign bit. For n ≥ WIDTH every result bit and the carry equal `src_val[WIDTH-1]`.
- R9: A rotate right by a nonzero n rotates by n mod WIDTH, and `carry_out` is the top bit of the result. A nonzero multiple of WIDTH therefore returns `src_val` unchanged, with a carry of `src_val[WIDTH-1]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_val | input | WIDTH | Word to be shifted |
| shift_kind | input | 2 | Operation select, 0..3 |
| amt_from_reg | input | 1 | 1: amount from `reg_amt`, 0: amount from `imm_amt` |
| imm_amt | input | IMM_BITS | Encoded immediate amount |
| reg_amt | input | WIDTH | Register amount word; only the low AMT_BITS bits are used |
| carry_in | input | 1 | Incoming carry flag |
| result | output | WIDTH | Shifted word |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 5-bit immediate and an 8-bit register amount. With these values, register amounts run up to 255, so the bench can reach counts far above the word width, the exact-width boundary, and every nonzero multiple of the width for rotation. An exhaustive sweep over all immediate codes and all register amounts, for every kind and several data patterns, is compared against a bit-by-bit reference model. Hand-worked literal vectors cover the decode edges.

// File: rtl/barrel_shift_carry.sv
module barrel_shift_carry #(
  parameter int WIDTH    = 32,
  parameter int IMM_BITS = 5,
  parameter int AMT_BITS = 8
) (
  input  logic [WIDTH-1:0]    src_val,
  input  logic [1:0]          shift_kind,
  input  logic                amt_from_reg,
  input  logic [IMM_BITS-1:0] imm_amt,
  input  logic [WIDTH-1:0]    reg_amt,
  input  logic                carry_in,
  output logic [WIDTH-1:0]    result,
  output logic                carry_out
);
  localparam int LOG_W = $clog2(WIDTH);

  typedef enum logic [2:0] {OP_SHL, OP_SHR, OP_SAR, OP_ROT, OP_ROTX} op_e;

  op_e                 op;
  logic [AMT_BITS-1:0] amt;
  logic [WIDTH:0]      shl_w, shr_w, sar_w;
  logic [WIDTH-1:0]    rot_w;
  logic [LOG_W-1:0]    rot_m;
  logic                unused_hi_amt;

  assign unused_hi_amt = ^reg_amt[WIDTH-1:AMT_BITS];

  always_comb begin
    op  = OP_SHL;
    amt = '0;
    if (amt_from_reg) begin
      amt = reg_amt[AMT_BITS-1:0];
      case (shift_kind)
        2'd0:    op = OP_SHL;
        2'd1:    op = OP_SHR;
        2'd2:    op = OP_SAR;
        default: op = OP_ROT;
      endcase
    end else begin
      case (shift_kind)
        2'd0: begin
          op  = OP_SHL;
          amt = AMT_BITS'(imm_amt);
        end
        2'd1, 2'd2: begin
          op  = (shift_kind == 2'd1) ? OP_SHR : OP_SAR;
          amt = (imm_amt == '0) ? AMT_BITS'(WIDTH) : AMT_BITS'(imm_amt);
        end
        default: begin
          if (imm_amt == '0) begin
            op  = OP_ROTX;
            amt = AMT_BITS'(1);
          end else begin
            op  = OP_ROT;
            amt = AMT_BITS'(imm_amt);
          end
        end
      endcase
    end
  end

  assign shl_w = {1'b0, src_val} << amt;
  assign shr_w = {src_val, 1'b0} >> amt;
  assign sar_w = $signed({src_val, 1'b0}) >>> amt;
  assign rot_m = amt[LOG_W-1:0];
  assign rot_w = WIDTH'({src_val, src_val} >> rot_m);

  always_comb begin
    result    = src_val;
    carry_out = carry_in;
    if (op == OP_ROTX) begin
      result    = {carry_in, src_val[WIDTH-1:1]};
      carry_out = src_val[0];
    end else if (amt != '0) begin
      case (op)
        OP_SHL: begin
          result    = shl_w[WIDTH-1:0];
          carry_out = shl_w[WIDTH];
        end
        OP_SHR: begin
          result    = shr_w[WIDTH:1];
          carry_out = shr_w[0];
        end
        OP_SAR: begin
          result    = sar_w[WIDTH:1];
          carry_out = sar_w[0];
        end
        default: begin
          result    = rot_w;
          carry_out = rot_w[WIDTH-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/barrel_shift_carry_chk.sv
module barrel_shift_carry_chk #(
  parameter int WIDTH    = 32,
  parameter int IMM_BITS = 5,
  parameter int AMT_BITS = 8
) (
  input logic [WIDTH-1:0]    src_val,
  input logic [1:0]          shift_kind,
  input logic                amt_from_reg,
  input logic [IMM_BITS-1:0] imm_amt,
  input logic [WIDTH-1:0]    reg_amt,
  input logic                carry_in,
  input logic [WIDTH-1:0]    result,
  input logic                carry_out
);
  logic [AMT_BITS-1:0] ramt;
  logic                unused_hi_chk;
  assign ramt          = reg_amt[AMT_BITS-1:0];
  assign unused_hi_chk = ^reg_amt[WIDTH-1:AMT_BITS];

  always_comb begin
    if (amt_from_reg && ramt == '0)
      AST_ZERO_PASS: assert (result == src_val && carry_out == carry_in); // R5
    if (!amt_from_reg && shift_kind == 2'd3 && imm_amt == '0)
      AST_ROTX_FORM: assert (result == {carry_in, src_val[WIDTH-1:1]} && carry_out == src_val[0]); // R3
    if (!amt_from_reg && shift_kind == 2'd1 && imm_amt == '0)
      AST_SHR_IMM_FULL: assert (result == '0 && carry_out == src_val[WIDTH-1]); // R2
    if (amt_from_reg && shift_kind == 2'd0 && ramt > AMT_BITS'(WIDTH))
      AST_SHL_OVER: assert (result == '0 && carry_out == 1'b0); // R6
    if (amt_from_reg && shift_kind == 2'd2 && ramt >= AMT_BITS'(WIDTH))
      AST_SAR_FILL: assert (result == {WIDTH{src_val[WIDTH-1]}} && carry_out == src_val[WIDTH-1]); // R8
    if (amt_from_reg && shift_kind == 2'd3 && ramt != '0 && (int'(ramt) % WIDTH) == 0)
      AST_ROT_WRAP: assert (result == src_val && carry_out == src_val[WIDTH-1]); // R9
    if (amt_from_reg && shift_kind == 2'd3)
      AST_ROT_CARRY_MSB: assert (ramt == '0 || carry_out == result[WIDTH-1]); // R9
  end
endmodule

bind barrel_shift_carry barrel_shift_carry_chk #(
  .WIDTH(WIDTH), .IMM_BITS(IMM_BITS), .AMT_BITS(AMT_BITS)
) u_chk (.*);

// File: tb/tb_barrel_shift_carry.sv
`timescale 1ns/1ps
module tb_barrel_shift_carry;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  src_val = '0;
  logic [1:0]    shift_kind = '0;
  logic          amt_from_reg = 1'b0;
  logic [4:0]    imm_amt = '0;
  logic [W-1:0]  reg_amt = '0;
  logic          carry_in = 1'b0;
  logic [W-1:0]  result;
  logic          carry_out;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  barrel_shift_carry #(.WIDTH(W), .IMM_BITS(5), .AMT_BITS(8)) dut (
    .src_val(src_val), .shift_kind(shift_kind), .amt_from_reg(amt_from_reg),
    .imm_amt(imm_amt), .reg_amt(reg_amt), .carry_in(carry_in),
    .result(result), .carry_out(carry_out));

  function automatic void model(input logic [W-1:0] s, input logic [1:0] k, input logic md,
                                input logic [4:0] im, input logic [W-1:0] ra, input logic ci,
                                output logic [W-1:0] r, output logic c);
    int n, op, idx;
    if (md) begin
      n = int'(ra[7:0]); op = int'(k);
    end else begin
      case (k)
        2'd0: begin op = 0; n = int'(im); end
        2'd1, 2'd2: begin op = int'(k); n = (im == 0) ? W : int'(im); end
        default: begin
          if (im == 0) begin op = 4; n = 1; end else begin op = 3; n = int'(im); end
        end
      endcase
    end
    r = s; c = ci;
    if (op == 4) begin
      for (int i = 0; i < W - 1; i++) r[i] = s[i+1];
      r[W-1] = ci; c = s[0];
    end else if (n != 0) begin
      for (int i = 0; i < W; i++) begin
        case (op)
          0: begin idx = i - n; r[i] = (idx >= 0) ? s[idx] : 1'b0; end
          1: begin idx = i + n; r[i] = (idx < W) ? s[idx] : 1'b0; end
          2: begin idx = i + n; r[i] = (idx < W) ? s[idx] : s[W-1]; end
          default: r[i] = s[(i + (n % W)) % W];
        endcase
      end
      case (op)
        0: c = (n <= W) ? s[W-n] : 1'b0;
        1: c = (n <= W) ? s[n-1] : 1'b0;
        2: c = (n <= W) ? s[n-1] : s[W-1];
        default: c = r[W-1];
      endcase
    end
  endfunction

  task automatic drive(input logic [W-1:0] s, input logic [1:0] k, input logic md,
                       input logic [4:0] im, input logic [W-1:0] ra, input logic ci);
    @(negedge clk);
    src_val = s; shift_kind = k; amt_from_reg = md; imm_amt = im; reg_amt = ra; carry_in = ci;
    #1;
  endtask

  task automatic compare(input string req, input logic [W-1:0] er, input logic ec);
    n_vec++;
    if (result !== er || carry_out !== ec) begin
      n_bad++;
      $display("FAIL %s: kind=%0d reg=%0b imm=%0d ramt=%h src=%h cin=%0b got %h/%0b expected %h/%0b",
               req, shift_kind, amt_from_reg, imm_amt, reg_amt, src_val, carry_in,
               result, carry_out, er, ec);
    end
  endtask

  task automatic lit(input string req, input logic [W-1:0] s, input logic [1:0] k, input logic md,
                     input logic [4:0] im, input logic [W-1:0] ra, input logic ci,
                     input logic [W-1:0] er, input logic ec);
    drive(s, k, md, im, ra, ci);
    compare(req, er, ec);
  endtask

  task automatic mdl(input string req, input logic [W-1:0] s, input logic [1:0] k, input logic md,
                     input logic [4:0] im, input logic [W-1:0] ra, input logic ci);
    logic [W-1:0] er; logic ec;
    model(s, k, md, im, ra, ci, er, ec);
    drive(s, k, md, im, ra, ci);
    compare(req, er, ec);
  endtask

  task automatic t_idle();
    lit("R1 idle", '0, 2'd0, 1'b0, 5'd0, '0, 1'b0, '0, 1'b0);
  endtask

  task automatic t_imm_left();
    lit("R1", 32'h8000_0001, 2'd0, 1'b0, 5'd1, '0, 1'b0, 32'h0000_0002, 1'b1);
    lit("R1", 32'h1234_5678, 2'd0, 1'b0, 5'd0, '0, 1'b1, 32'h1234_5678, 1'b1);
    lit("R6", 32'h0800_0000, 2'd0, 1'b0, 5'd4, '0, 1'b0, 32'h8000_0000, 1'b0);
  endtask

  task automatic t_imm_right_zero();
    lit("R2", 32'h8000_0000, 2'd1, 1'b0, 5'd0, '0, 1'b0, 32'h0000_0000, 1'b1);
    lit("R2", 32'h8000_0000, 2'd2, 1'b0, 5'd0, '0, 1'b0, 32'hFFFF_FFFF, 1'b1);
    lit("R2", 32'h7FFF_FFFF, 2'd2, 1'b0, 5'd0, '0, 1'b1, 32'h0000_0000, 1'b0);
  endtask

  task automatic t_imm_rotate();
    lit("R3", 32'h1234_56F8, 2'd3, 1'b0, 5'd8, '0, 1'b0, 32'hF812_3456, 1'b1);
    lit("R3", 32'h0000_0003, 2'd3, 1'b0, 5'd0, '0, 1'b1, 32'h8000_0001, 1'b1);
    lit("R3", 32'h0000_0002, 2'd3, 1'b0, 5'd0, '0, 1'b0, 32'h0000_0001, 1'b0);
  endtask

  task automatic t_reg_map();
    lit("R4", 32'h0000_0001, 2'd0, 1'b1, 5'd0, 32'hABCD_0101, 1'b0, 32'h0000_0002, 1'b0);
    lit("R4", 32'h0000_0005, 2'd3, 1'b1, 5'd0, 32'h0000_0100, 1'b1, 32'h0000_0005, 1'b1);
    lit("R4", 32'h0000_00F8, 2'd1, 1'b1, 5'd0, 32'hFFFF_FF04, 1'b0, 32'h0000_000F, 1'b1);
  endtask

  task automatic t_zero_amount();
    for (int k = 0; k < 4; k++)
      lit("R5", 32'h0000_F0F0, 2'(k), 1'b1, 5'd7, 32'h0000_0000, 1'b1, 32'h0000_F0F0, 1'b1);
  endtask

  task automatic t_edges();
    lit("R6", 32'h0000_0001, 2'd0, 1'b1, 5'd0, 32'd32, 1'b0, 32'h0, 1'b1);
    lit("R6", 32'hFFFF_FFFF, 2'd0, 1'b1, 5'd0, 32'd33, 1'b1, 32'h0, 1'b0);
    lit("R7", 32'h8000_0000, 2'd1, 1'b1, 5'd0, 32'd32, 1'b0, 32'h0, 1'b1);
    lit("R7", 32'hFFFF_FFFF, 2'd1, 1'b1, 5'd0, 32'd40, 1'b1, 32'h0, 1'b0);
    lit("R8", 32'h8000_0000, 2'd2, 1'b1, 5'd0, 32'd200, 1'b0, 32'hFFFF_FFFF, 1'b1);
    lit("R8", 32'hF000_0008, 2'd2, 1'b1, 5'd0, 32'd4, 1'b0, 32'hFF00_0000, 1'b1);
    lit("R9", 32'h8000_0001, 2'd3, 1'b1, 5'd0, 32'd64, 1'b0, 32'h8000_0001, 1'b1);
    lit("R9", 32'h0000_0010, 2'd3, 1'b1, 5'd0, 32'd36, 1'b1, 32'h0000_0001, 1'b0);
  endtask

  task automatic t_sweep();
    logic [W-1:0] pats [3];
    pats[0] = 32'h8000_0001; pats[1] = 32'h5A3C_96E1; pats[2] = 32'h7FFF_FFFE;
    for (int p = 0; p < 3; p++)
      for (int k = 0; k < 4; k++) begin
        for (int a = 0; a < 32; a++)
          mdl("R1 R2 R3 sweep", pats[p], 2'(k), 1'b0, 5'(a), 32'hDEAD_BE00, 1'(p));
        for (int a = 0; a < 256; a++)
          mdl("R4 R6 R7 R8 R9 sweep", pats[p], 2'(k), 1'b1, 5'd0, {24'h5A5A5A, 8'(a)}, 1'(p + 1));
      end
  endtask

  initial begin
    #150000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_imm_left();
    t_imm_right_zero();
    t_imm_rotate();
    t_reg_map();
    t_zero_amount();
    t_edges();
    t_sweep();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule